// File: doc/BRIEF.md
# Odd-Parity Asynchronous Serial Receiver

This block takes one asynchronous serial line and turns each character on it into a parallel byte. The line rests high. A character opens with a low start bit. Eight data bits follow, lowest bit first. Then come an odd-parity bit and one high stop bit. The bit period is a whole number of system clocks, set by a parameter. The default of 434 clocks suits 115200 bit/s on a 50 MHz clock.

The line input passes through two flip-flops before any logic uses it. A falling edge starts a half-bit timer. If the line has gone high again when that timer expires, the event is treated as noise and dropped. Otherwise every following bit is sampled once, at the middle of its period. The stop bit is sampled the same way. At that moment the byte and two error flags are loaded, and a valid strobe is raised for one clock. The byte and flags then hold until the next character completes.

Top module: `odd_uart_rx`

## Requirements
- R1: While rst_ni is low, and after its release, data_o, valid_o, parity_err_o and frame_err_o are all 0.
- R2: A line held high produces no valid_o strobe. A character starts only on a high-to-low transition of the line.
- R3: A low pulse shorter than half a bit period is rejected, and no strobe follows it.
- R4: The eight data bits arrive least significant bit first. data_o holds them with the first received bit at position 0.
- R5: parity_err_o is 1 exactly when the number of ones across the eight data bits and the parity bit is even. For example, 0x00 with parity 1 and 0x01 with parity 0 are both error-free.
- R6: frame_err_o is 1 exactly when the stop bit samples low. The byte is still delivered with its strobe.
- R7: valid_o is high for one clock per character. data_o, parity_err_o and frame_err_o change only in the cycle valid_o rises, and hold their values between strobes.
- R8: A start bit that directly follows a good stop bit, with no idle time between them, is received correctly.
- R9: Each bit is sampled once, CLKS_PER_BIT clocks after the previous sample. The first sample of the start bit falls CLKS_PER_BIT/2 clocks after the synchronised falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial line, idles high |
| data_o | output | DATA_BITS | Last received byte |
| valid_o | output | 1 | One-clock strobe marking a new character |
| parity_err_o | output | 1 | Odd-parity check failed on the last character |
| frame_err_o | output | 1 | Stop bit of the last character sampled low |

## Verification
Most internal faults show up at the ports within one character. A bit counter that is off by one, a shift in the wrong direction, or a wrong half-bit point gives a wrong byte or wrong flags at the next strobe. A sampling point that drifts shows most clearly on alternating patterns and on back-to-back characters. There, a late sample falls into the next bit and corrupts the byte or the stop check. A state machine that fails to return to idle shows as a missing strobe, or as a spurious strobe after a rejected glitch.

// File: rtl/odd_uart_rx_pkg.sv
`timescale 1ns/1ps
package odd_uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/odd_uart_sync.sv
`timescale 1ns/1ps
module odd_uart_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  // resets to the idle level so reset release is not seen as a start edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/odd_uart_bit_timer.sv
`timescale 1ns/1ps
module odd_uart_bit_timer #(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic half_o,
  output logic full_o
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (cnt_q != FULL_LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign half_o = (cnt_q == HALF_LAST);
  assign full_o = (cnt_q == FULL_LAST);

  assert_cnt_in_period_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_LAST);
  assert_cnt_steps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !full_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/odd_uart_deser.sv
`timescale 1ns/1ps
module odd_uart_deser #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic                 bit_i,
  output logic [DATA_BITS-1:0] word_o
);
  logic [DATA_BITS-1:0] sh_q;

  // first bit on the line ends up at position 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= {bit_i, sh_q[DATA_BITS-1:1]};
  end

  assign word_o = sh_q;

  assert_shift_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sh_q));
endmodule

// File: rtl/odd_uart_rx.sv
`timescale 1ns/1ps
module odd_uart_rx
  import odd_uart_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 parity_err_o,
  output logic                 frame_err_o
);
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

  rx_state_e            state_q, state_d;
  logic [IDX_W-1:0]     idx_q;
  logic                 rx_s;
  logic                 half_hit, full_hit, tmr_clr;
  logic                 par_q;
  logic                 shift_en;
  logic [DATA_BITS-1:0] word;

  odd_uart_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
  );

  odd_uart_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr),
    .half_o(half_hit), .full_o(full_hit)
  );

  odd_uart_deser #(.DATA_BITS(DATA_BITS)) u_deser (
    .clk_i (clk_i), .rst_ni(rst_ni), .shift_i(shift_en),
    .bit_i (rx_s), .word_o(word)
  );

  assign shift_en = (state_q == RX_DATA) && full_hit;
  assign tmr_clr  = (state_q == RX_IDLE) ||
                    ((state_q == RX_START) && half_hit) || full_hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RX_IDLE:  if (!rx_s) state_d = RX_START;
      RX_START: if (half_hit) state_d = rx_s ? RX_IDLE : RX_DATA;
      RX_DATA:  if (full_hit && idx_q == LAST_IDX) state_d = RX_PAR;
      RX_PAR:   if (full_hit) state_d = RX_STOP;
      RX_STOP:  if (full_hit) state_d = RX_IDLE;
      default:  state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= RX_IDLE;
      idx_q        <= '0;
      par_q        <= 1'b0;
      data_o       <= '0;
      valid_o      <= 1'b0;
      parity_err_o <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_o <= 1'b0;
      if (state_q == RX_START) idx_q <= '0;
      else if (shift_en)       idx_q <= idx_q + 1'b1;
      if ((state_q == RX_PAR) && full_hit) par_q <= rx_s;
      if ((state_q == RX_STOP) && full_hit) begin
        valid_o      <= 1'b1;
        data_o       <= word;
        parity_err_o <= ~(^{word, par_q});
        frame_err_o  <= ~rx_s;
      end
    end
  end

  assert_valid_one_clock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_outputs_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(data_o) && $stable(parity_err_o) && $stable(frame_err_o)));
  assert_valid_after_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> ($past(state_q) == RX_STOP));
  assert_glitch_dropped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && half_hit && rx_s) |=> (state_q == RX_IDLE && !valid_o));
  assert_idle_needs_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_IDLE && rx_s) |=> (state_q == RX_IDLE));
endmodule

// File: tb/odd_uart_rx_tb.sv
`timescale 1ns/1ps
module odd_uart_rx_tb_top;
  localparam time CLK_PERIOD = 20ns;
  localparam int  CPB        = 16;
  localparam int  WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [7:0] data;
  logic       valid, perr, ferr;

  int checks = 0;
  int fails  = 0;
  int strobes = 0;
  bit done = 0;

  typedef struct packed { logic [7:0] d; logic pe; logic fe; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  odd_uart_rx #(.CLKS_PER_BIT(CPB), .DATA_BITS(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx),
    .data_o(data), .valid_o(valid), .parity_err_o(perr), .frame_err_o(ferr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx = b;
    repeat (CPB) @(negedge clk);
  endtask

  // good_par: send the odd-parity bit; good_stop: send a high stop bit
  task automatic send(input logic [7:0] d, input bit good_par, input bit good_stop);
    logic p;
    exp_t e;
    p = good_par ? ~(^d) : (^d);
    e.d = d; e.pe = ~good_par; e.fe = ~good_stop;
    exp_q.push_back(e);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    drive_bit(p);
    drive_bit(good_stop);
  endtask

  // monitor: compares each strobe against the scoreboard
  logic last_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (last_valid) chk(valid == 1'b0, "R7 strobe width", valid, 0);
      if (valid) begin
        exp_t e;
        strobes++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected strobe", data, 0);
        end else begin
          e = exp_q.pop_front();
          chk(data == e.d, "R4 data", data, e.d);
          chk(perr == e.pe, "R5 parity flag", perr, e.pe);
          chk(ferr == e.fe, "R6 frame flag", ferr, e.fe);
        end
      end
      last_valid <= valid;
    end
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    chk({data, valid, perr, ferr} == 11'd0, "R1 in reset", {data, valid, perr, ferr}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({data, valid, perr, ferr} == 11'd0, "R1 after release", {data, valid, perr, ferr}, 0);

    // R2: long idle produces nothing
    repeat (20 * CPB) @(negedge clk);
    chk(strobes == 0, "R2 idle line", strobes, 0);

    // R4 R5: varied patterns with good parity, some idle between
    send(8'h00, 1, 1); drive_bit(1'b1);
    send(8'h01, 1, 1); drive_bit(1'b1);
    send(8'hA5, 1, 1); drive_bit(1'b1);
    send(8'hFF, 1, 1); drive_bit(1'b1);
    send(8'h80, 1, 1); drive_bit(1'b1);
    send(8'h55, 1, 1); drive_bit(1'b1);

    // R5: wrong parity
    send(8'h3C, 0, 1); drive_bit(1'b1);
    send(8'h00, 0, 1); drive_bit(1'b1);

    // R6: low stop bit, then enough idle to resync
    send(8'h5A, 1, 0); drive_bit(1'b1); drive_bit(1'b1);
    send(8'hC3, 0, 0); drive_bit(1'b1); drive_bit(1'b1);

    // R3: short low glitch must be dropped
    repeat (2 * CPB) @(negedge clk);
    n = strobes;
    rx = 1'b0; repeat (CPB / 4) @(negedge clk);
    rx = 1'b1; repeat (3 * CPB) @(negedge clk);
    chk(strobes == n, "R3 glitch rejected", strobes, n);

    // R8 R9: back-to-back characters, no idle between stop and start
    send(8'h12, 1, 1);
    send(8'h34, 1, 1);
    send(8'hE7, 0, 1);
    send(8'h9B, 1, 1);
    drive_bit(1'b1); drive_bit(1'b1);

    repeat (3 * CPB) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all characters seen", exp_q.size(), 0);
    chk(strobes == 14, "R9 strobe count", strobes, 14);
    // R7: last outputs still held well after strobe
    chk(data == 8'h9B && !perr && !ferr, "R7 outputs held", {data, perr, ferr}, {8'h9B, 2'b00});
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule